// File: doc/BRIEF.md
# Legacy SMI Event Status Register

This block is the 32-bit control/status word of a USB host controller's legacy-support capability. It records events that system-management firmware needs to see. Three sticky flags are set by hardware and stay set until firmware writes a 1 to them. One flag marks a write to the base address register. One marks a write to the PCI command register. One marks a change of the OS-ownership semaphore in either direction.

Six further bits are read-only copies of the host controller's interrupt status bits. They follow their sources, so firmware clears them by clearing the source status in the controller's operational registers.

The register is held in the always-on (suspend) power well. Only the suspend-well reset clears it. A core-well reset or a warm power-state return leaves its contents intact. Address decoding, the SMI enable bits and the SMI output logic sit outside this block. The block sees an already-decoded write strobe with data and drives its read value at all times.

Top module: `legacy_smi_status`

## Requirements
- R1: While `sus_rst_n` is low at a rising clock edge, the whole register becomes 00000000h. No other input clears it as a whole.
- R2: Bit 31 becomes 1 on the edge after an edge at which `bar_wr_pulse` is high. It then stays 1 until it is cleared under R5.
- R3: Bit 30 becomes 1 on the edge after an edge at which `cmd_wr_pulse` is high. It then stays 1 until it is cleared under R5.
- R4: Bit 29 becomes 1 when `os_owned_sem` differs from its value at the previous clock edge, for both a 0-to-1 and a 1-to-0 change. The level present during reset is taken as the starting value, so releasing reset with the semaphore at 1 sets nothing.
- R5: A write (`wr_en` high) with `wr_data[31]`, `wr_data[30]` or `wr_data[29]` at 1 clears the matching sticky bit. A 0 in those positions leaves the bit unchanged.
- R6: If a hardware set event and a write-1 clear hit the same sticky bit at the same edge, the bit ends up set.
- R7: Bits 21 down to 16 show `hc_sts[5:0]` as sampled at the previous edge, in this mapping: bit 21 = async advance (`hc_sts[5]`), 20 = host system error, 19 = frame list rollover, 18 = port change detect, 17 = USB error, 16 = USB interrupt (`hc_sts[0]`). Writes do not affect these bits.
- R8: Bits 28:22 and 15:0 always read 0, and writes to them are ignored.
- R9: With no event, no toggle and no write, the sticky bits keep their values from edge to edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Suspend-well clock |
| sus_rst_n | input | 1 | Active-low synchronous suspend-well reset |
| wr_en | input | 1 | Decoded write strobe for this register |
| wr_data | input | 32 | Write data; ones in bits 31:29 clear sticky flags |
| bar_wr_pulse | input | 1 | One-cycle strobe: base address register written |
| cmd_wr_pulse | input | 1 | One-cycle strobe: PCI command register written |
| os_owned_sem | input | 1 | Level of the OS-ownership semaphore |
| hc_sts | input | 6 | Host controller interrupt status bits 5:0 |
| rd_data | output | 32 | Current register value |

## Verification
Every result of this block is due exactly one rising edge after its cause. This applies to a set strobe, a semaphore change, a write-1 clear, a shadow update and the reset. The bench drives each stimulus on a falling edge and compares `rd_data` on the following falling edge. At that point exactly one capturing edge has passed, and nothing changes before the next drive. The table rows follow one another, so each expected word builds on the state left by the row before it. The semaphore row pairs and the reset-release test check that toggle detection compares against the previous edge and not against a reset default.

// File: rtl/lss_pkg.sv
package lss_pkg;

  localparam int REG_W     = 32;
  localparam int STS_W     = 6;
  localparam int NUM_EVT   = 3;
  // Sticky flag positions; firmware decodes these.
  localparam int POS_BAR   = 31;
  localparam int POS_CMD   = 30;
  localparam int POS_SEM   = 29;
  localparam int EVT_LSB   = POS_SEM;
  localparam int SHD_LSB   = 16;
  localparam int SHD_MSB   = SHD_LSB + STS_W - 1;

  // Index of each sticky event within the event vector (LSB = semaphore).
  localparam int EV_SEM = 0;
  localparam int EV_CMD = 1;
  localparam int EV_BAR = 2;

  // Next value of a write-1-to-clear flag: a set beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Assemble the visible word; everything not named reads as zero.
  function automatic logic [REG_W-1:0] pack_word(input logic [NUM_EVT-1:0] ev,
                                                 input logic [STS_W-1:0] shd);
    logic [REG_W-1:0] w;
    w = '0;
    w[EVT_LSB +: NUM_EVT] = ev;
    w[SHD_LSB +: STS_W]   = shd;
    return w;
  endfunction

endpackage

// File: rtl/lss_sticky_bit.sv
module lss_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  import lss_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= sticky_next(flag, set_evt, clr_req);
  end

  // R2
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R5
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> $stable(flag));

endmodule

// File: rtl/lss_toggle_det.sv
module lss_toggle_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic toggled
);
  logic level_q;

  // During reset the copy follows the input, so release gives no false edge.
  always_ff @(posedge clk) begin
    level_q <= level;
  end

  assign toggled = level ^ level_q;

  // R4
  toggle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toggled == (level != $past(level)));

endmodule

// File: rtl/lss_shadow.sv
module lss_shadow #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] mirror
);

  always_ff @(posedge clk) begin
    if (!rst_n) mirror <= '0;
    else        mirror <= src;
  end

  // R7
  shadow_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mirror == $past(src));

endmodule

// File: rtl/legacy_smi_status.sv
module legacy_smi_status
  import lss_pkg::*;
(
  input  logic             clk,
  input  logic             sus_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bar_wr_pulse,
  input  logic             cmd_wr_pulse,
  input  logic             os_owned_sem,
  input  logic [STS_W-1:0] hc_sts,
  output logic [REG_W-1:0] rd_data
);

  // Named internal events for the checks below.
  logic                 sem_toggled;
  logic [NUM_EVT-1:0]   evt_set;
  logic [NUM_EVT-1:0]   evt_clr;
  logic [NUM_EVT-1:0]   evt_flag;
  logic [STS_W-1:0]     sts_shadow;
  logic                 unused_wr_bits;

  // Only the sticky positions respond to writes.
  assign unused_wr_bits = ^wr_data[EVT_LSB-1:0];

  lss_toggle_det u_sem_tog (
    .clk     (clk),
    .rst_n   (sus_rst_n),
    .level   (os_owned_sem),
    .toggled (sem_toggled)
  );

  assign evt_set[EV_SEM] = sem_toggled;
  assign evt_set[EV_CMD] = cmd_wr_pulse;
  assign evt_set[EV_BAR] = bar_wr_pulse;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign evt_clr[i] = wr_en & wr_data[EVT_LSB + i];

    lss_sticky_bit u_flag (
      .clk     (clk),
      .rst_n   (sus_rst_n),
      .set_evt (evt_set[i]),
      .clr_req (evt_clr[i]),
      .flag    (evt_flag[i])
    );
  end

  lss_shadow #(.W(STS_W)) u_shadow (
    .clk    (clk),
    .rst_n  (sus_rst_n),
    .src    (hc_sts),
    .mirror (sts_shadow)
  );

  assign rd_data = pack_word(evt_flag, sts_shadow);

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!sus_rst_n)
    (bar_wr_pulse && wr_en && wr_data[POS_BAR]) |=> rd_data[POS_BAR]);

  // R3
  cmd_flag_chk: assert property (@(posedge clk) disable iff (!sus_rst_n)
    cmd_wr_pulse |=> rd_data[POS_CMD]);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!sus_rst_n)
    wr_en |=> (rd_data[28:22] == '0) && (rd_data[SHD_LSB-1:0] == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !sus_rst_n |=> rd_data == '0);

endmodule

// File: tb/legacy_smi_status_bench.sv
module legacy_smi_status_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic        bar;
    logic        cmd;
    logic        sem;
    logic [5:0]  sts;
    logic        we;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Rows run in order; each expected word builds on the previous row.
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,6'h00,1'b0,32'h0000_0000,32'h0000_0000,4'd9}, // R9 idle
    '{1'b1,1'b0,1'b0,6'h00,1'b0,32'h0000_0000,32'h8000_0000,4'd2}, // R2 set
    '{1'b0,1'b0,1'b0,6'h00,1'b0,32'h0000_0000,32'h8000_0000,4'd2}, // R2 sticky
    '{1'b0,1'b1,1'b0,6'h00,1'b0,32'h0000_0000,32'hC000_0000,4'd3}, // R3 set
    '{1'b0,1'b0,1'b0,6'h00,1'b1,32'h0000_0000,32'hC000_0000,4'd5}, // R5 zeros
    '{1'b0,1'b0,1'b0,6'h00,1'b1,32'h8000_0000,32'h4000_0000,4'd5}, // R5 clear
    '{1'b0,1'b0,1'b1,6'h00,1'b0,32'h0000_0000,32'h6000_0000,4'd4}, // R4 rise
    '{1'b0,1'b0,1'b1,6'h00,1'b1,32'h2000_0000,32'h4000_0000,4'd4}, // R4 steady
    '{1'b0,1'b0,1'b0,6'h00,1'b0,32'h0000_0000,32'h6000_0000,4'd4}, // R4 fall
    '{1'b0,1'b0,1'b0,6'h00,1'b1,32'hFFFF_FFFF,32'h0000_0000,4'd8}, // R8 all ones
    '{1'b0,1'b0,1'b0,6'h2A,1'b0,32'h0000_0000,32'h002A_0000,4'd7}, // R7
    '{1'b0,1'b0,1'b0,6'h15,1'b0,32'h0000_0000,32'h0015_0000,4'd7}, // R7
    '{1'b0,1'b0,1'b0,6'h15,1'b1,32'h003F_0000,32'h0015_0000,4'd7}, // R7 ro
    '{1'b0,1'b0,1'b0,6'h00,1'b0,32'h0000_0000,32'h0000_0000,4'd7}, // R7 drop
    '{1'b1,1'b0,1'b0,6'h00,1'b1,32'h8000_0000,32'h8000_0000,4'd6}, // R6
    '{1'b0,1'b1,1'b1,6'h00,1'b1,32'hC000_0000,32'h6000_0000,4'd6}, // R6 mix
    '{1'b0,1'b0,1'b1,6'h3F,1'b1,32'hFFFF_FFFF,32'h003F_0000,4'd5}, // R5 all
    '{1'b0,1'b0,1'b1,6'h3F,1'b0,32'h0000_0000,32'h003F_0000,4'd9}  // R9 hold
  };

  logic        clk = 1'b0;
  logic        sus_rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        bar_wr_pulse;
  logic        cmd_wr_pulse;
  logic        os_owned_sem;
  logic [5:0]  hc_sts;
  logic [31:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_smi_status u_legacy_smi_status (
    .clk          (clk),
    .sus_rst_n    (sus_rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .bar_wr_pulse (bar_wr_pulse),
    .cmd_wr_pulse (cmd_wr_pulse),
    .os_owned_sem (os_owned_sem),
    .hc_sts       (hc_sts),
    .rd_data      (rd_data)
  );

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%08h expected=%08h", req, rd_data, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_data = '0; bar_wr_pulse = 1'b0; cmd_wr_pulse = 1'b0;
  endtask

  initial begin
    sus_rst_n = 1'b0; os_owned_sem = 1'b0; hc_sts = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'h0);
    sus_rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bar_wr_pulse = VECS[i].bar;
      cmd_wr_pulse = VECS[i].cmd;
      os_owned_sem = VECS[i].sem;
      hc_sts       = VECS[i].sts;
      wr_en        = VECS[i].we;
      wr_data      = VECS[i].wd;
      @(negedge clk);
      check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R1: suspend reset clears set flags and shadow.
    idle_inputs();
    bar_wr_pulse = 1'b1; cmd_wr_pulse = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R1 before reset", 32'hC03F_0000);
    sus_rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", 32'h0);

    // R4: semaphore high across reset release gives no toggle.
    hc_sts = '0; os_owned_sem = 1'b1;
    @(negedge clk);
    sus_rst_n = 1'b1;
    @(negedge clk);
    check("R4 no toggle on release", 32'h0);
    os_owned_sem = 1'b0;
    @(negedge clk);
    check("R4 fall after release", 32'h2000_0000);

    // R8: write ones to reserved positions only.
    wr_en = 1'b1; wr_data = 32'h1FC0_FFFF;
    @(negedge clk);
    idle_inputs();
    check("R8 reserved write", 32'h2000_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule